// File: doc/BRIEF.md
# Tag-Only Set-Associative Cache Controller

This block tracks which memory blocks a data cache would hold, without storing any data. A client presents one request at a time: a load, a store, a read-modify-write, or an instruction fetch, each with a byte address and a byte count. The controller splits the request into one lookup per block touched. It reports every lookup as a hit or a miss, flags when a resident block has to make room, and names the block to fill and the block being displaced. When a displaced block holds unwritten store data, the controller also raises a writeback request for it.

The geometry and policies are set at run time within compile-time limits. These are the number of sets, the block size, the number of ways, exact least-recently-used or pseudo-random victim choice, and write-through or write-back. It is meant to sit beside a cycle-cost or memory model that acts on its fill and writeback requests.

Top module: `cache_tag_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it is released, `req_ready` is 1 and `done_valid`, `fill_req` and `wb_req` are 0.
- R2: `req_op` codes are 0 = load, 1 = store, 2 = modify, 3 = instruction fetch. Each lookup produces one `done_valid` pulse with exactly one of `done_hit` and `done_miss` set. A lookup hits when its block address (`req_addr >> cfg_blk_log2`) is resident in set `blk & (2^cfg_sets_log2 - 1)`.
- R3: On a miss, a way that holds no block (among the first `cfg_ways` ways) is filled before any resident block is displaced. `done_evict` is set only on a miss into a set whose `cfg_ways` ways are all occupied.
- R4: With `cfg_lru`=1 the displaced block is the one whose last lookup is older than that of every other block in the set, and `evict_blk` carries its block address.
- R5: With `cfg_lru`=0 the displaced block is chosen by a free-running 16-bit LFSR taken modulo `cfg_ways`. `evict_blk` always names a block that was resident in that set.
- R6: A store that misses raises `fill_req` for `done_blk` (fetch-on-write), and the block is resident afterwards.
- R7: A modify performs all its load lookups (`done_store`=0) and then repeats the same lookups as stores (`done_store`=1). A plain store reports `done_store`=1, and a load reports 0.
- R8: A request covers the blocks from the one holding `req_addr` to the one holding `req_addr+req_size-1`, in ascending order, one lookup each. A size of 0 counts as 1 byte.
- R9: With `cfg_wb`=1 a store marks its block dirty, and displacing a dirty block raises `wb_req` alongside `evict_blk`. With `cfg_wb`=0, `wb_req` never rises.
- R10: An instruction fetch (code 3) is accepted, leaves `req_ready` high, produces no lookup and changes no cache state.
- R11: The controller takes one request at a time. After any request other than a fetch is accepted, `req_ready` stays low until the cycle of its last `done_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sets_log2 | input | SL_W | log2 of the active set count |
| cfg_blk_log2 | input | BL_W | log2 of the block size in bytes |
| cfg_ways | input | WCNT_W | Active number of ways |
| cfg_lru | input | 1 | 1 = exact LRU, 0 = pseudo-random victim |
| cfg_wb | input | 1 | 1 = write-back, 0 = write-through |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_op | input | 2 | Operation code |
| req_addr | input | ADDR_W | First byte address |
| req_size | input | SIZE_W | Byte count |
| done_valid | output | 1 | One lookup finished |
| done_hit | output | 1 | Lookup hit |
| done_miss | output | 1 | Lookup missed |
| done_evict | output | 1 | A resident block was displaced |
| done_store | output | 1 | Lookup was a store |
| done_blk | output | BA_W | Block address looked up |
| fill_req | output | 1 | `done_blk` must be fetched |
| wb_req | output | 1 | `evict_blk` is dirty and must be written back |
| evict_blk | output | BA_W | Block address displaced |

## Verification
The bench builds the block with its defaults: up to 16 sets, 4 ways, and blocks of 8 to 64 bytes. This is enough to run direct-mapped, two-way, full four-way and three-way random geometries after successive resets. The small sets make conflict evictions, dirty writebacks and exact recency ordering frequent within a few dozen requests. The narrow blocks make accesses that straddle two blocks easy to produce, including modifies that straddle.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_MODIFY = 2'd2,
    OP_IFETCH = 2'd3
  } cache_op_e;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_LOOK = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/cache_lfsr.sv
module cache_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] value
);
  always_ff @(posedge clk) begin
    if (rst) value <= SEED;
    else     value <= {1'b0, value[15:1]} ^ (value[0] ? 16'hB400 : 16'h0000);
  end
endmodule

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
  parameter int MAX_WAYS = 4,
  parameter int BA_W     = 29,
  parameter int WAY_W    = 2
) (
  input  logic [MAX_WAYS-1:0][BA_W-1:0] tags,
  input  logic [MAX_WAYS-1:0]           valid,
  input  logic [BA_W-1:0]               blk,
  output logic                          hit,
  output logic [WAY_W-1:0]              hit_way
);
  logic [MAX_WAYS-1:0] eq;

  for (genvar g = 0; g < MAX_WAYS; g++) begin : g_cmp
    assign eq[g] = valid[g] && (tags[g] == blk);
  end

  always_comb begin
    hit     = |eq;
    hit_way = '0;
    for (int j = 0; j < MAX_WAYS; j++)
      if (eq[j]) hit_way = WAY_W'(j);
  end
endmodule

// File: rtl/cache_victim_pick.sv
module cache_victim_pick #(
  parameter int MAX_WAYS = 4,
  parameter int WAY_W    = 2,
  parameter int WCNT_W   = 3
) (
  input  logic [MAX_WAYS-1:0]            valid,
  input  logic [MAX_WAYS-1:0][WAY_W-1:0] rank,
  input  logic [WCNT_W-1:0]              ways,
  input  logic                           use_lru,
  input  logic [15:0]                    rnd,
  output logic [WAY_W-1:0]               way,
  output logic                           way_valid
);
  logic [WCNT_W-1:0] ways_eff;
  logic              inv_found;
  logic [WAY_W-1:0]  inv_way, lru_way, best, rnd_way;
  logic [15:0]       rmod;

  always_comb begin
    if (ways == '0)                       ways_eff = WCNT_W'(1);
    else if (ways > WCNT_W'(MAX_WAYS))    ways_eff = WCNT_W'(MAX_WAYS);
    else                                  ways_eff = ways;

    inv_found = 1'b0;
    inv_way   = '0;
    for (int j = MAX_WAYS - 1; j >= 0; j--)
      if (WCNT_W'(j) < ways_eff && !valid[j]) begin
        inv_found = 1'b1;
        inv_way   = WAY_W'(j);
      end

    lru_way = '0;
    best    = '0;
    for (int j = 0; j < MAX_WAYS; j++)
      if (WCNT_W'(j) < ways_eff && rank[j] >= best) begin
        best    = rank[j];
        lru_way = WAY_W'(j);
      end

    rmod    = rnd % 16'(ways_eff);
    rnd_way = rmod[WAY_W-1:0];

    way       = inv_found ? inv_way : (use_lru ? lru_way : rnd_way);
    way_valid = !inv_found;
  end
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import cache_tag_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int SIZE_W        = 8,
  parameter int MAX_SETS_LOG2 = 4,
  parameter int MAX_WAYS      = 4,
  parameter int MIN_BLK_LOG2  = 3,
  parameter int MAX_BLK_LOG2  = 6,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int BA_W   = ADDR_W - MIN_BLK_LOG2,
  localparam int WAY_W  = (MAX_WAYS > 1) ? $clog2(MAX_WAYS) : 1,
  localparam int WCNT_W = $clog2(MAX_WAYS + 1),
  localparam int SL_W   = $clog2(MAX_SETS_LOG2 + 1),
  localparam int BL_W   = $clog2(MAX_BLK_LOG2 + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SL_W-1:0]   cfg_sets_log2,
  input  logic [BL_W-1:0]   cfg_blk_log2,
  input  logic [WCNT_W-1:0] cfg_ways,
  input  logic              cfg_lru,
  input  logic              cfg_wb,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  output logic              done_valid,
  output logic              done_hit,
  output logic              done_miss,
  output logic              done_evict,
  output logic              done_store,
  output logic [BA_W-1:0]   done_blk,
  output logic              fill_req,
  output logic              wb_req,
  output logic [BA_W-1:0]   evict_blk
);
  localparam int NSETS = 1 << MAX_SETS_LOG2;

  ctrl_state_e state_q;
  cache_op_e   op_q;
  logic        phase_st_q;
  logic [BA_W-1:0] cur_q, first_q, last_q;

  logic [MAX_WAYS-1:0][BA_W-1:0]  tag_q   [NSETS];
  logic [MAX_WAYS-1:0]            val_q   [NSETS];
  logic [MAX_WAYS-1:0]            dirty_q [NSETS];
  logic [MAX_WAYS-1:0][WAY_W-1:0] rank_q  [NSETS];

  logic [MAX_SETS_LOG2-1:0] set_mask, set_idx;
  logic [SIZE_W-1:0]        size_m1;
  logic [15:0]              rnd;
  logic                     hit, vic_valid, accept, miss_evict;
  logic [WAY_W-1:0]         hit_way, vic_way, way_sel;

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign size_m1    = (req_size == '0) ? '0 : req_size - 1'b1;
  assign set_idx    = cur_q[MAX_SETS_LOG2-1:0] & set_mask;
  assign way_sel    = hit ? hit_way : vic_way;
  assign miss_evict = !hit && vic_valid;

  always_comb begin
    set_mask = '0;
    for (int b = 0; b < MAX_SETS_LOG2; b++)
      if (SL_W'(b) < cfg_sets_log2) set_mask[b] = 1'b1;
  end

  cache_lfsr #(.SEED(LFSR_SEED)) u_lfsr (.clk(clk), .rst(rst), .value(rnd));

  cache_tag_match #(.MAX_WAYS(MAX_WAYS), .BA_W(BA_W), .WAY_W(WAY_W)) u_match (
    .tags(tag_q[set_idx]), .valid(val_q[set_idx]), .blk(cur_q),
    .hit(hit), .hit_way(hit_way)
  );

  cache_victim_pick #(.MAX_WAYS(MAX_WAYS), .WAY_W(WAY_W), .WCNT_W(WCNT_W)) u_pick (
    .valid(val_q[set_idx]), .rank(rank_q[set_idx]), .ways(cfg_ways),
    .use_lru(cfg_lru), .rnd(rnd), .way(vic_way), .way_valid(vic_valid)
  );

  // Tag store: no reset, written only on a fill.
  always_ff @(posedge clk) begin
    if (state_q == ST_LOOK && !hit) tag_q[set_idx][vic_way] <= cur_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      op_q       <= OP_LOAD;
      phase_st_q <= 1'b0;
      cur_q      <= '0;
      first_q    <= '0;
      last_q     <= '0;
      done_valid <= 1'b0;
      done_hit   <= 1'b0;
      done_miss  <= 1'b0;
      done_evict <= 1'b0;
      done_store <= 1'b0;
      done_blk   <= '0;
      fill_req   <= 1'b0;
      wb_req     <= 1'b0;
      evict_blk  <= '0;
      for (int s = 0; s < NSETS; s++) begin
        val_q[s]   <= '0;
        dirty_q[s] <= '0;
        for (int j = 0; j < MAX_WAYS; j++) rank_q[s][j] <= WAY_W'(j);
      end
    end else begin
      done_valid <= 1'b0;
      done_hit   <= 1'b0;
      done_miss  <= 1'b0;
      done_evict <= 1'b0;
      fill_req   <= 1'b0;
      wb_req     <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept && cache_op_e'(req_op) != OP_IFETCH) begin
            state_q    <= ST_LOOK;
            op_q       <= cache_op_e'(req_op);
            phase_st_q <= (cache_op_e'(req_op) == OP_STORE);
            first_q    <= BA_W'(req_addr >> cfg_blk_log2);
            cur_q      <= BA_W'(req_addr >> cfg_blk_log2);
            last_q     <= BA_W'((req_addr + ADDR_W'(size_m1)) >> cfg_blk_log2);
          end
        end
        ST_LOOK: begin
          done_valid <= 1'b1;
          done_hit   <= hit;
          done_miss  <= !hit;
          done_evict <= miss_evict;
          done_store <= phase_st_q;
          done_blk   <= cur_q;
          fill_req   <= !hit;
          wb_req     <= miss_evict && dirty_q[set_idx][vic_way] && cfg_wb;
          evict_blk  <= miss_evict ? tag_q[set_idx][vic_way] : '0;
          val_q[set_idx][way_sel] <= 1'b1;
          if (hit) begin
            if (phase_st_q && cfg_wb) dirty_q[set_idx][way_sel] <= 1'b1;
          end else begin
            dirty_q[set_idx][way_sel] <= phase_st_q && cfg_wb;
          end
          for (int j = 0; j < MAX_WAYS; j++) begin
            if (WAY_W'(j) == way_sel)
              rank_q[set_idx][j] <= '0;
            else if (rank_q[set_idx][j] < rank_q[set_idx][way_sel])
              rank_q[set_idx][j] <= rank_q[set_idx][j] + 1'b1;
          end
          if (cur_q == last_q) begin
            if (op_q == OP_MODIFY && !phase_st_q) begin
              phase_st_q <= 1'b1;
              cur_q      <= first_q;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            cur_q <= cur_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache_tag_ctrl_chk.sv
module cache_tag_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_wb,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_op,
  input logic       done_valid,
  input logic       done_hit,
  input logic       done_miss,
  input logic       done_evict,
  input logic       fill_req,
  input logic       wb_req
);
  p_one_outcome_r2: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> $countones({done_hit, done_miss}) == 1);

  p_evict_on_miss_r3: assert property (@(posedge clk) disable iff (rst)
    done_evict |-> (done_valid && done_miss));

  p_fill_on_miss_r6: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_miss) |-> fill_req);

  p_wt_no_writeback_r9: assert property (@(posedge clk) disable iff (rst)
    !cfg_wb |-> !wb_req);

  p_wb_needs_evict_r9: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> done_evict);

  p_fetch_stays_ready_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op == 2'd3) |=> req_ready);

  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op != 2'd3) |=> !req_ready);
endmodule

bind cache_tag_ctrl cache_tag_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cfg_wb(cfg_wb), .req_valid(req_valid),
  .req_ready(req_ready), .req_op(req_op), .done_valid(done_valid),
  .done_hit(done_hit), .done_miss(done_miss), .done_evict(done_evict),
  .fill_req(fill_req), .wb_req(wb_req)
);

// File: tb/cache_tag_ctrl_tb.sv
module cache_tag_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cfg_sets_log2 = '0;
  logic [2:0]  cfg_blk_log2 = 3'd3;
  logic [2:0]  cfg_ways = 3'd1;
  logic        cfg_lru = 1'b1;
  logic        cfg_wb = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_size = '0;
  logic        done_valid, done_hit, done_miss, done_evict, done_store;
  logic [28:0] done_blk, evict_blk;
  logic        fill_req, wb_req;

  always #10ns clk = ~clk;

  cache_tag_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_sets_log2(cfg_sets_log2), .cfg_blk_log2(cfg_blk_log2),
    .cfg_ways(cfg_ways), .cfg_lru(cfg_lru), .cfg_wb(cfg_wb),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_size(req_size),
    .done_valid(done_valid), .done_hit(done_hit), .done_miss(done_miss),
    .done_evict(done_evict), .done_store(done_store), .done_blk(done_blk),
    .fill_req(fill_req), .wb_req(wb_req), .evict_blk(evict_blk)
  );

  int checks = 0;
  int fails  = 0;
  int c_sets_log2, c_blk, c_ways, c_lru, c_wb;

  // Reference model: per set, block addresses ordered most recent first.
  int unsigned mq [16][$];
  bit          dm [int unsigned];
  int unsigned pend_blk [$];
  bit          pend_st  [$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && done_valid) begin
      if (pend_blk.size() == 0) begin
        chk(1'b0, "R11 done pulse with no lookup pending", 1, 0);
      end else begin
        int unsigned b, s, vb;
        bit st, e_hit, e_evict, e_wb;
        int found, vidx;
        b = pend_blk.pop_front();
        st = pend_st.pop_front();
        s = b & ((32'd1 << c_sets_log2) - 1);
        found = -1;
        for (int k = 0; k < mq[s].size(); k++) if (mq[s][k] == b) found = k;
        e_hit = (found >= 0);
        e_evict = 1'b0;
        e_wb = 1'b0;
        vb = 0;
        chk(done_hit == e_hit, "R2 hit", done_hit, e_hit);
        chk(done_miss == !e_hit, "R2 miss", done_miss, !e_hit);
        chk(done_blk == b, "R8 block order", done_blk, b);
        chk(done_store == st, "R7 store phase", done_store, st);
        chk(fill_req == !e_hit, "R6 fill request", fill_req, !e_hit);
        if (e_hit) begin
          mq[s].delete(found);
          mq[s].push_front(b);
          if (st && c_wb != 0) dm[b] = 1'b1;
        end else begin
          if (mq[s].size() >= c_ways) begin
            e_evict = 1'b1;
            if (c_lru != 0) begin
              vidx = mq[s].size() - 1;
              vb = mq[s][vidx];
              chk(evict_blk == vb, "R4 LRU victim", evict_blk, vb);
            end else begin
              vb = evict_blk;
              vidx = -1;
              for (int k = 0; k < mq[s].size(); k++) if (mq[s][k] == vb) vidx = k;
              chk(vidx >= 0, "R5 random victim resident", evict_blk, mq[s][0]);
              if (vidx < 0) vidx = mq[s].size() - 1;
              vb = mq[s][vidx];
            end
            e_wb = (c_wb != 0) && dm.exists(vb) && dm[vb];
            mq[s].delete(vidx);
            if (dm.exists(vb)) dm.delete(vb);
          end
          mq[s].push_front(b);
          if (st && c_wb != 0) dm[b] = 1'b1;
        end
        chk(done_evict == e_evict, "R3 evict flag", done_evict, e_evict);
        chk(wb_req == e_wb, "R9 writeback", wb_req, e_wb);
      end
    end
  end

  task automatic do_reset(input int sl2, input int bl2, input int ways, input int lru, input int wb);
    rst = 1'b1;
    c_sets_log2 = sl2; c_blk = bl2; c_ways = ways; c_lru = lru; c_wb = wb;
    cfg_sets_log2 = 3'(sl2); cfg_blk_log2 = 3'(bl2); cfg_ways = 3'(ways);
    cfg_lru = 1'(lru); cfg_wb = 1'(wb);
    for (int s = 0; s < 16; s++) mq[s].delete();
    dm.delete();
    pend_blk.delete();
    pend_st.delete();
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && done_valid == 1'b0, "R1 during reset", {req_ready, done_valid}, 2);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(done_valid == 1'b0 && fill_req == 1'b0 && wb_req == 1'b0, "R1 outputs quiet",
        {done_valid, fill_req, wb_req}, 0);
  endtask

  task automatic send(input logic [1:0] op, input int unsigned addr, input int unsigned size);
    int unsigned first, last, sm1;
    int phases;
    if (op != 2'd3) begin
      sm1 = (size == 0) ? 0 : size - 1;
      first = addr >> c_blk;
      last = (addr + sm1) >> c_blk;
      phases = (op == 2'd2) ? 2 : 1;
      for (int p = 0; p < phases; p++)
        for (int unsigned b = first; b <= last; b++) begin
          pend_blk.push_back(b);
          pend_st.push_back((op == 2'd1) || (op == 2'd2 && p == 1));
        end
    end
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_size = 8'(size);
    @(negedge clk);
    req_valid = 1'b0;
    if (op == 2'd3) chk(req_ready == 1'b1, "R10 fetch leaves controller idle", req_ready, 1);
    else            chk(req_ready == 1'b0, "R11 busy after accept", req_ready, 0);
  endtask

  task automatic drain();
    int t = 0;
    while ((pend_blk.size() != 0 || !req_ready) && t < 1000) begin
      @(negedge clk);
      t++;
    end
    repeat (2) @(negedge clk);
    chk(pend_blk.size() == 0, "R11 all lookups reported", pend_blk.size(), 0);
  endtask

  initial begin
    // Two-way, 4 sets, 16-byte blocks, LRU, write-back.
    do_reset(2, 4, 2, 1, 1);
    send(2'd0, 32'h000, 4);
    send(2'd0, 32'h040, 4);
    send(2'd0, 32'h004, 4);
    send(2'd1, 32'h080, 4);   // R6 store miss, R4 evicts block 4
    send(2'd0, 32'h000, 4);
    send(2'd0, 32'h0C0, 4);   // R9 evicts dirty block 8
    send(2'd2, 32'h044, 4);   // R7 load miss then store hit
    send(2'd0, 32'h01C, 8);   // R8 straddles blocks 1 and 2
    send(2'd2, 32'h0FC, 8);   // R7 and R8 modify straddling sets 3 and 0
    send(2'd1, 32'h040, 1);
    send(2'd3, 32'h300, 4);   // R10 fetch ignored
    send(2'd0, 32'h300, 4);   // must miss
    send(2'd0, 32'h080, 0);   // R8 size 0 is one byte
    drain();

    // Direct mapped, write-through, 8-byte blocks.
    do_reset(2, 3, 1, 1, 0);
    for (int i = 0; i < 12; i++)
      send((i % 3 == 0) ? 2'd1 : ((i % 3 == 1) ? 2'd2 : 2'd0), (i % 4) * 32 + (i % 2) * 4, 4);
    send(2'd0, 32'h006, 4);
    drain();

    // Three ways, random victims, 2 sets, 32-byte blocks, write-back.
    do_reset(1, 5, 3, 0, 1);
    for (int i = 0; i < 40; i++)
      send((i % 3 == 0) ? 2'd1 : 2'd0, ((i * 7) % 6) * 64 + (i % 2) * 32, 4);
    drain();

    // Four ways, 16 sets, 64-byte blocks, LRU, write-through.
    do_reset(4, 6, 4, 1, 0);
    for (int i = 0; i < 60; i++)
      send(2'(i % 3), ((i * 37) % 11) * 1024 + (i % 3) * 60, 8);
    drain();

    // Four ways, LRU, write-back with repeated dirty conflicts.
    do_reset(3, 3, 4, 1, 1);
    for (int i = 0; i < 40; i++)
      send((i % 2 == 0) ? 2'd1 : 2'd2, ((i * 5) % 7) * 64, 8);
    drain();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R11 watchdog expired: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule